// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block sequences a small 16-bit processor that needs several clock cycles for each instruction. It tracks where the current instruction is in its fetch, decode and execute steps. From that step, the instruction's 3-bit opcode, its 4-bit function code and a register-equality flag, it drives the strobes and selects that steer the datapath. It does not contain the datapath, the memory or the register file.

Every instruction starts with one fetch cycle and one decode cycle. During fetch the memory is read at the program counter and the instruction register is loaded. In the same cycle the shared ALU adds one to the program counter. In decode the datapath reads the two source registers, and the controller picks the execute path. The execute path takes one to three cycles, depending on the instruction. Control then returns to fetch, except after the halt instruction, which holds the controller still until reset.

The controller is a Moore machine, with one exception: the program-counter load in the branch state follows the equality flag within the same cycle.

Top module: `mc_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the controller enters the fetch step. The first cycle after reset is released therefore drives the fetch outputs of R2.
- R2: In the fetch step the following outputs are 1: `pc_ld`, `ma_pc_en`, `mem_rd` and `ir_ld`. The selects are `alu_b_sel`=1 (constant one), `alu_a_sel`=0 (PC) and `alu_op`=0 (add). Every other output is 0.
- R3: The cycle after fetch is a decode cycle in which every output is 0.
- R4: For opcode 0 with function code 0 to 4, a single execute cycle follows decode. In that cycle `rf_we`=1, `rf_waddr_sel`=0 (rd), `rf_wdata_sel`=0 (ALU), `alu_a_sel`=1 (register A) and `alu_b_sel`=0 (register B). `alu_op` equals the function code, where 0=add, 1=sub, 2=and, 3=or and 4=set-less-than. Control then returns to fetch.
- R5: Opcode 1 (load) runs three execute cycles:
  - an address cycle with `alu_a_sel`=1, `alu_b_sel`=2 (sign-extended offset) and `alu_op`=0;
  - a read cycle with `ma_alu_en`=1 and `mem_rd`=1;
  - a write-back cycle with `rf_we`=1, `rf_wdata_sel`=1 (memory) and `rf_waddr_sel`=1 (rt).
  Control then returns to fetch.
- R6: Opcode 2 (store) runs the same address cycle as R5, then a write cycle with `ma_alu_en`=1 and `mem_wr`=1. Control then returns to fetch.
- R7: Opcode 4 (add immediate) runs one cycle with `rf_we`=1, `rf_waddr_sel`=1, `rf_wdata_sel`=0, `alu_a_sel`=1, `alu_b_sel`=2 and `alu_op`=0. Control then returns to fetch.
- R8: Opcode 3 (branch if equal) runs one cycle with `alu_a_sel`=0, `alu_b_sel`=2, `alu_op`=0 and `pc_src`=0. In that cycle `pc_ld` equals `rs_eq_rt`. The ALU therefore adds the offset to the program counter, which fetch has already advanced. Control then returns to fetch.
- R9: Opcode 5 (jump) runs one cycle with `pc_ld`=1 and `pc_src`=1 (jump target). Control then returns to fetch.
- R10: After the decode cycle of opcode 7 (halt), every output stays 0 on every cycle until reset, whatever the opcode, function code and equality inputs do.
- R11: Opcode 6, and opcode 0 with a function code of 5 to 15, go straight from decode back to fetch. No write strobe is asserted in between.
- R12: In the outputs of R2 to R10, every output that is not listed is 0.
- R13: `mem_rd` and `mem_wr` are never both 1, and at most one of `ma_pc_en` and `ma_alu_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_opcode | input | 3 | Opcode field of the instruction register |
| ir_funct | input | 4 | Function-code field of the instruction register |
| rs_eq_rt | input | 1 | Datapath flag: the two source registers are equal |
| pc_ld | output | 1 | Load the program counter |
| pc_src | output | 1 | PC source: 0 ALU result, 1 jump target |
| ma_pc_en | output | 1 | Drive the memory address from the PC |
| ma_alu_en | output | 1 | Drive the memory address from the ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_ld | output | 1 | Load the instruction register |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B input: 0 register B, 1 constant one, 2 sign-extended offset |
| alu_op | output | 3 | ALU operation: 0 add, 1 sub, 2 and, 3 or, 4 set-less-than |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata_sel | output | 1 | Write data: 0 ALU, 1 memory |
| rf_waddr_sel | output | 1 | Write register: 0 rd, 1 rt |

## Verification
The hardest situation to bring about is the halt state under changing inputs. Reaching it takes a full fetch and decode with opcode 7. Inside halt the opcode, function code and equality flag must then move to values that would launch other paths if the controller were still decoding. The bench holds the halt instruction through both cycles before the halt state. It then varies the three inputs on each parked cycle and expects all outputs at zero. Only after that does it apply reset and confirm that a normal instruction runs again. The branch state is also exercised with the equality flag both high and low.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int OP_W   = 3;
  localparam int FN_W   = 4;
  localparam int AOP_W  = 3;
  localparam int BSEL_W = 2;

  localparam logic [OP_W-1:0] OPC_RTYPE = 3'd0;
  localparam logic [OP_W-1:0] OPC_LOAD  = 3'd1;
  localparam logic [OP_W-1:0] OPC_STORE = 3'd2;
  localparam logic [OP_W-1:0] OPC_BEQ   = 3'd3;
  localparam logic [OP_W-1:0] OPC_ADDI  = 3'd4;
  localparam logic [OP_W-1:0] OPC_JUMP  = 3'd5;
  localparam logic [OP_W-1:0] OPC_HALT  = 3'd7;

  localparam logic [AOP_W-1:0] ALU_ADD = 3'd0;
  localparam logic [AOP_W-1:0] ALU_SUB = 3'd1;
  localparam logic [AOP_W-1:0] ALU_AND = 3'd2;
  localparam logic [AOP_W-1:0] ALU_OR  = 3'd3;
  localparam logic [AOP_W-1:0] ALU_SLT = 3'd4;

  localparam logic [BSEL_W-1:0] B_REG = 2'd0;
  localparam logic [BSEL_W-1:0] B_ONE = 2'd1;
  localparam logic [BSEL_W-1:0] B_OFS = 2'd2;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_RALU, S_ADDI, S_MADDR, S_LDMEM,
    S_LDWB, S_STMEM, S_BRANCH, S_JUMP, S_PARK
  } state_t;

  typedef struct packed {
    logic              pc_ld;
    logic              pc_src;
    logic              ma_pc_en;
    logic              ma_alu_en;
    logic              mem_rd;
    logic              mem_wr;
    logic              ir_ld;
    logic              alu_a_sel;
    logic [BSEL_W-1:0] alu_b_sel;
    logic [AOP_W-1:0]  alu_op;
    logic              rf_we;
    logic              rf_wdata_sel;
    logic              rf_waddr_sel;
  } ctrl_t;

  // Function code to ALU operation; unknown codes map to add (never used).
  function automatic logic [AOP_W-1:0] funct_to_aluop(input logic [FN_W-1:0] fn);
    case (fn)
      4'd0:    return ALU_ADD;
      4'd1:    return ALU_SUB;
      4'd2:    return ALU_AND;
      4'd3:    return ALU_OR;
      4'd4:    return ALU_SLT;
      default: return ALU_ADD;
    endcase
  endfunction

  function automatic logic funct_known(input logic [FN_W-1:0] fn);
    return fn <= 4'd4;
  endfunction

  // Execute entry chosen in the decode step.
  function automatic state_t dispatch(input logic [OP_W-1:0] op,
                                      input logic [FN_W-1:0] fn);
    case (op)
      OPC_RTYPE: return funct_known(fn) ? S_RALU : S_FETCH;
      OPC_LOAD:  return S_MADDR;
      OPC_STORE: return S_MADDR;
      OPC_BEQ:   return S_BRANCH;
      OPC_ADDI:  return S_ADDI;
      OPC_JUMP:  return S_JUMP;
      OPC_HALT:  return S_PARK;
      default:   return S_FETCH;
    endcase
  endfunction
endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
  import mcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  state_t nxt,
  output state_t cur
);
  always_ff @(posedge clk) begin
    if (!rst_n) cur <= S_FETCH;
    else        cur <= nxt;
  end
endmodule

// File: rtl/mcc_sequencer.sv
module mcc_sequencer
  import mcc_pkg::*;
(
  input  state_t          cur,
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output state_t          nxt
);
  always_comb begin
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: nxt = dispatch(opcode, funct);
      S_MADDR:  nxt = (opcode == OPC_LOAD) ? S_LDMEM : S_STMEM;
      S_LDMEM:  nxt = S_LDWB;
      S_PARK:   nxt = S_PARK;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mcc_strobes.sv
module mcc_strobes
  import mcc_pkg::*;
(
  input  state_t          cur,
  input  logic [FN_W-1:0] funct,
  input  logic            rs_eq_rt,
  output ctrl_t           ctl
);
  always_comb begin
    ctl = '0;
    case (cur)
      S_FETCH: begin
        ctl.ma_pc_en  = 1'b1;
        ctl.mem_rd    = 1'b1;
        ctl.ir_ld     = 1'b1;
        ctl.alu_b_sel = B_ONE;
        ctl.alu_op    = ALU_ADD;
        ctl.pc_ld     = 1'b1;
      end
      S_RALU: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = B_REG;
        ctl.alu_op    = funct_to_aluop(funct);
        ctl.rf_we     = 1'b1;
      end
      S_ADDI: begin
        ctl.alu_a_sel    = 1'b1;
        ctl.alu_b_sel    = B_OFS;
        ctl.rf_we        = 1'b1;
        ctl.rf_waddr_sel = 1'b1;
      end
      S_MADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = B_OFS;
      end
      S_LDMEM: begin
        ctl.ma_alu_en = 1'b1;
        ctl.mem_rd    = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_we        = 1'b1;
        ctl.rf_wdata_sel = 1'b1;
        ctl.rf_waddr_sel = 1'b1;
      end
      S_STMEM: begin
        ctl.ma_alu_en = 1'b1;
        ctl.mem_wr    = 1'b1;
      end
      S_BRANCH: begin
        ctl.alu_b_sel = B_OFS;
        ctl.pc_ld     = rs_eq_rt;
      end
      S_JUMP: begin
        ctl.pc_ld  = 1'b1;
        ctl.pc_src = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   ir_opcode,
  input  logic [FN_W-1:0]   ir_funct,
  input  logic              rs_eq_rt,
  output logic              pc_ld,
  output logic              pc_src,
  output logic              ma_pc_en,
  output logic              ma_alu_en,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              ir_ld,
  output logic              alu_a_sel,
  output logic [BSEL_W-1:0] alu_b_sel,
  output logic [AOP_W-1:0]  alu_op,
  output logic              rf_we,
  output logic              rf_wdata_sel,
  output logic              rf_waddr_sel
);
  state_t cur, nxt;
  ctrl_t  ctl;

  mcc_state_reg u_state (.clk(clk), .rst_n(rst_n), .nxt(nxt), .cur(cur));
  mcc_sequencer u_seq (.cur(cur), .opcode(ir_opcode), .funct(ir_funct), .nxt(nxt));
  mcc_strobes   u_str (.cur(cur), .funct(ir_funct), .rs_eq_rt(rs_eq_rt), .ctl(ctl));

  // Named events for the checker.
  logic in_park;
  logic undef_dispatch;
  assign in_park        = (cur == S_PARK);
  assign undef_dispatch = (cur == S_DECODE) && (nxt == S_FETCH);

  assign pc_ld        = ctl.pc_ld;
  assign pc_src       = ctl.pc_src;
  assign ma_pc_en     = ctl.ma_pc_en;
  assign ma_alu_en    = ctl.ma_alu_en;
  assign mem_rd       = ctl.mem_rd;
  assign mem_wr       = ctl.mem_wr;
  assign ir_ld        = ctl.ir_ld;
  assign alu_a_sel    = ctl.alu_a_sel;
  assign alu_b_sel    = ctl.alu_b_sel;
  assign alu_op       = ctl.alu_op;
  assign rf_we        = ctl.rf_we;
  assign rf_wdata_sel = ctl.rf_wdata_sel;
  assign rf_waddr_sel = ctl.rf_waddr_sel;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pc_ld,
  input logic pc_src,
  input logic ma_pc_en,
  input logic ma_alu_en,
  input logic mem_rd,
  input logic mem_wr,
  input logic ir_ld,
  input logic rf_we,
  input logic rf_wdata_sel,
  input logic in_park,
  input logic undef_dispatch
);
  // R13
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R13
  addr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ma_pc_en, ma_alu_en}));
  // R2
  fetch_bundle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |-> (pc_ld && mem_rd && ma_pc_en));
  // R3
  decode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |=> !(pc_ld || rf_we || mem_rd || mem_wr || ir_ld));
  // R5
  load_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && ma_alu_en) |=> (rf_we && rf_wdata_sel));
  // R6
  store_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> ir_ld);
  // R9
  jump_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld && pc_src) |=> ir_ld);
  // R10
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_park |=> (in_park && !pc_ld && !rf_we && !mem_wr && !mem_rd && !ir_ld));
  // R11
  undef_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_dispatch |=> ir_ld);
endmodule

bind mc_ctrl mc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pc_ld(pc_ld), .pc_src(pc_src),
  .ma_pc_en(ma_pc_en), .ma_alu_en(ma_alu_en), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .ir_ld(ir_ld), .rf_we(rf_we),
  .rf_wdata_sel(rf_wdata_sel), .in_park(in_park),
  .undef_dispatch(undef_dispatch)
);

// File: tb/mc_ctrl_tb.sv
`timescale 1ns/1ps
module mc_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] ir_opcode = '0;
  logic [3:0] ir_funct = '0;
  logic rs_eq_rt = 1'b0;
  logic pc_ld, pc_src, ma_pc_en, ma_alu_en, mem_rd, mem_wr, ir_ld, alu_a_sel;
  logic [1:0] alu_b_sel;
  logic [2:0] alu_op;
  logic rf_we, rf_wdata_sel, rf_waddr_sel;

  always #2.5 clk = ~clk;

  mc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .ir_funct(ir_funct),
    .rs_eq_rt(rs_eq_rt), .pc_ld(pc_ld), .pc_src(pc_src), .ma_pc_en(ma_pc_en),
    .ma_alu_en(ma_alu_en), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .rf_we(rf_we), .rf_wdata_sel(rf_wdata_sel), .rf_waddr_sel(rf_waddr_sel)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  // Bit order: pc_ld pc_src ma_pc ma_alu rd wr ir asel bsel[2] op[3] we wds was
  function automatic logic [15:0] mk(bit pl, bit ps, bit mp, bit ma, bit rd,
      bit wr, bit ir, bit as, bit [1:0] bs, bit [2:0] op, bit we, bit wd, bit wa);
    return {pl, ps, mp, ma, rd, wr, ir, as, bs, op, we, wd, wa};
  endfunction

  function automatic logic [15:0] observed();
    return {pc_ld, pc_src, ma_pc_en, ma_alu_en, mem_rd, mem_wr, ir_ld,
            alu_a_sel, alu_b_sel, alu_op, rf_we, rf_wdata_sel, rf_waddr_sel};
  endfunction

  task automatic push(input logic [15:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // Monitor: compare one expected item per cycle, mid-cycle.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (observed() !== e) begin
        errors++;
        $display("FAIL %s: got %04h expected %04h", t, observed(), e);
      end
    end
  end

  // Driver: called at posedge+1 while the design is in fetch.
  task automatic issue(input bit [2:0] op, input bit [3:0] fn, input bit eq,
                       input string ftag);
    int n;
    ir_opcode = op; ir_funct = fn; rs_eq_rt = eq;
    push(mk(1,0,1,0,1,0,1,0,2'd1,3'd0,0,0,0), ftag);       // R2 fetch
    push('0, "R3");                                          // decode
    case (op)
      3'd0: if (fn <= 4) begin
              push(mk(0,0,0,0,0,0,0,1,2'd0,fn[2:0],1,0,0), "R4");
              n = 3;
            end else n = 2;                                   // R11
      3'd1: begin
              push(mk(0,0,0,0,0,0,0,1,2'd2,3'd0,0,0,0), "R5");
              push(mk(0,0,0,1,1,0,0,0,2'd0,3'd0,0,0,0), "R5");
              push(mk(0,0,0,0,0,0,0,0,2'd0,3'd0,1,1,1), "R5");
              n = 5;
            end
      3'd2: begin
              push(mk(0,0,0,0,0,0,0,1,2'd2,3'd0,0,0,0), "R6");
              push(mk(0,0,0,1,0,1,0,0,2'd0,3'd0,0,0,0), "R6");
              n = 4;
            end
      3'd3: begin push(mk(eq,0,0,0,0,0,0,0,2'd2,3'd0,0,0,0), "R8"); n = 3; end
      3'd4: begin push(mk(0,0,0,0,0,0,0,1,2'd2,3'd0,1,0,1), "R7"); n = 3; end
      3'd5: begin push(mk(1,1,0,0,0,0,0,0,2'd0,3'd0,0,0,0), "R9"); n = 3; end
      default: n = 2;                                         // R11 opcode 6
    endcase
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic issue_halt(input int park_cycles);
    ir_opcode = 3'd7; ir_funct = 4'd0; rs_eq_rt = 1'b0;
    push(mk(1,0,1,0,1,0,1,0,2'd1,3'd0,0,0,0), "R2");
    push('0, "R3");
    repeat (2) @(posedge clk);
    #1;
    for (int i = 0; i < park_cycles; i++) begin
      push('0, "R10");
      ir_opcode = i[2:0]; ir_funct = i[3:0]; rs_eq_rt = i[0];
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    issue(3'd0, 4'd0, 1'b0, "R1");   // add, first fetch after reset
    issue(3'd0, 4'd1, 1'b1, "R2");   // sub
    issue(3'd0, 4'd2, 1'b0, "R2");   // and
    issue(3'd0, 4'd3, 1'b0, "R2");   // or
    issue(3'd0, 4'd4, 1'b0, "R2");   // slt
    issue(3'd1, 4'd9, 1'b1, "R2");   // load
    issue(3'd2, 4'd7, 1'b0, "R2");   // store
    issue(3'd4, 4'd5, 1'b0, "R2");   // add immediate
    issue(3'd3, 4'd0, 1'b1, "R2");   // branch taken
    issue(3'd3, 4'd0, 1'b0, "R2");   // branch not taken
    issue(3'd5, 4'd0, 1'b1, "R2");   // jump
    issue(3'd6, 4'd0, 1'b1, "R11");  // undefined opcode
    issue(3'd0, 4'd5, 1'b0, "R11");  // undefined funct
    issue(3'd0, 4'd15, 1'b1, "R11"); // undefined funct, top value
    issue(3'd2, 4'd0, 1'b0, "R13");  // store right after undefined
    issue_halt(8);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    issue(3'd0, 4'd4, 1'b0, "R1");   // runs again after reset
    issue(3'd1, 4'd0, 1'b0, "R12");
    issue_halt(3);
    @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12: %0d expected items left, expected 0", exp_q.size());
    end
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end
endmodule